// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst into a synchronous pipelined SRAM. When a burst begins, a load strobe captures a full external address together with an ordering mode. On every later clock, the block either moves to the next beat or, while the advance input is inactive, repeats the current beat. Only the two lowest address bits change during a burst. The upper bits stay at the value that was loaded.

Two beat orders are offered. The linear order adds the beat count to the start offset and wraps inside the aligned four-word group. The interleaved order XORs the start offset with the beat count. The mode is captured together with the address, so one burst always follows one order. Outputs are registered: each load or advance becomes visible on the cycle after the clock edge that samples it.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `addr_o` and `offset_o` are zero on the next cycle. The captured mode returns to linear.
- R2: When `load_i` is 1 at an edge, `addr_o` equals the sampled `addr_i` on the next cycle. This is beat 0 of a new burst.
- R3: A load takes priority over an advance in the same cycle: when `load_i` is 1, the value of `adv_n_i` does not matter and the beat count restarts at 0.
- R4: With the linear order (`mode_i` = 0 at load), each advance (`adv_n_i` = 0, `load_i` = 0) sets `offset_o` to (previous offset + 1) mod 4. Example: a start of 2 gives 2, 3, 0, 1.
- R5: With the interleaved order (`mode_i` = 1 at load), beat n has `offset_o` = start offset XOR (n mod 4). Example: a start of 1 gives 1, 0, 3, 2, and a start of 3 gives 3, 2, 1, 0.
- R6: When `adv_n_i` is 1 and `load_i` is 0, `addr_o` repeats its current value.
- R7: `addr_o[ADDR_W-1:2]` changes only through a load. It holds the loaded upper bits for the whole burst.
- R8: Advances after the fourth beat keep cycling through the same four offsets in the same order, inside the same four-word group.
- R9: `mode_i` is sampled only at a load. Changing it during a burst does not alter the order of that burst.
- R10: `offset_o` always equals the low two bits of `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Start a burst from `addr_i` |
| addr_i | input | ADDR_W | External start address |
| adv_n_i | input | 1 | Advance to next beat, active low |
| mode_i | input | 1 | Beat order at load: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current beat address |
| offset_o | output | 2 | Current burst offset (low address bits) |

## Verification
Every result is due exactly one cycle after the rising edge that samples the load, advance, hold or reset. No output has a combinational path from an input. The bench drives inputs on the falling edge. At each rising edge, a behavioural model built from integers applies the same sampled inputs. At the next falling edge, the bench compares both outputs with that model, so each check lands in the single cycle where the result is due. Each check is tagged with the requirement that the sampled action exercises. The upper address bits are compared separately under their own tag.

// File: rtl/burst_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes a power-of-two burst length; only the ordering enum is shared.
package burst_pkg;

    // Beat ordering captured with each load.
    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
// Module: burst_beat_ctr
// Counts the beats of a burst modulo 2**BEAT_W. A clear restarts at beat 0
// and wins over a step; with neither, the count holds.
// Assumes clear and step are synchronous to clk.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [BEAT_W-1:0] beat_o
);

    logic [BEAT_W-1:0] beat_q;

    // Beat register: reset, clear on load, increment on advance, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (clear_i) begin
            beat_q <= '0;
        end else if (step_i) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign beat_o = beat_q;

    // R3
    clear_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (beat_q == '0));

    // R8
    step_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i) |=> (beat_q == BEAT_W'($past(beat_q) + 1'b1)));

    // R6
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clear_i) |=> $stable(beat_q));

endmodule

// File: rtl/burst_load_reg.sv
// Module: burst_load_reg
// Captures the upper address, the start offset and the ordering mode when
// a burst is loaded, and holds them until the next load.
// Assumes load is synchronous to clk.
module burst_load_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2,
    localparam int HI_W  = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mode_i,
    output logic [HI_W-1:0]   hi_o,
    output logic [BEAT_W-1:0] start_o,
    output burst_order_e      order_o
);

    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] start_q;
    burst_order_e      order_q;

    // Burst context: reset to zero/linear, capture everything on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= '0;
            order_q <= ORDER_LINEAR;
        end else if (load_i) begin
            hi_q    <= addr_i[ADDR_W-1:BEAT_W];
            start_q <= addr_i[BEAT_W-1:0];
            order_q <= burst_order_e'(mode_i);
        end
    end

    assign hi_o    = hi_q;
    assign start_o = start_q;
    assign order_o = order_q;

    // R9
    order_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(order_q));

    // R7
    hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(hi_q));

endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps the start offset and the beat count to the offset of the current
// beat: linear order adds modulo 2**BEAT_W, interleaved order XORs.
// Purely combinational; assumes both inputs are registered upstream.
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  burst_order_e      order_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [BEAT_W-1:0] offset_o
);

    logic [BEAT_W-1:0] lin_off;
    logic [BEAT_W-1:0] xor_off;

    // Per-bit XOR form of the interleaved order.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
        assign xor_off[b] = start_i[b] ^ beat_i[b];
    end

    // Wrapping add for the linear order.
    always_comb begin
        lin_off = start_i + beat_i;
    end

    // Order select.
    always_comb begin
        case (order_i)
            ORDER_XOR: offset_o = xor_off;
            default:   offset_o = lin_off;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen
// Top of the burst address sequencer. A load captures the address and
// mode; an active-low advance steps the beat; otherwise the beat repeats.
// The output address joins the held upper bits with the mapped offset.
// Assumes all inputs are synchronous to clk; the outputs are registered
// state with no combinational path from the inputs.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        offset_o
);

    localparam int BEAT_W = 2;
    localparam int HI_W   = ADDR_W - BEAT_W;

    logic [HI_W-1:0]   hi_w;
    logic [BEAT_W-1:0] start_w;
    logic [BEAT_W-1:0] beat_w;
    logic [BEAT_W-1:0] off_w;
    burst_order_e      order_w;
    logic              step_w;

    // An advance counts only when no load is present.
    always_comb begin
        step_w = !adv_n_i && !load_i;
    end

    burst_load_reg #(
        .ADDR_W (ADDR_W),
        .BEAT_W (BEAT_W)
    ) u_ctx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .addr_i  (addr_i),
        .mode_i  (mode_i),
        .hi_o    (hi_w),
        .start_o (start_w),
        .order_o (order_w)
    );

    burst_beat_ctr #(
        .BEAT_W (BEAT_W)
    ) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_i),
        .step_i  (step_w),
        .beat_o  (beat_w)
    );

    burst_order_map #(
        .BEAT_W (BEAT_W)
    ) u_map (
        .order_i  (order_w),
        .start_i  (start_w),
        .beat_i   (beat_w),
        .offset_o (off_w)
    );

    assign addr_o   = {hi_w, off_w};
    assign offset_o = off_w;

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(addr_i)));

    // R6
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> $stable(addr_o));

    // R7
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W])));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && order_w == ORDER_LINEAR)
            |=> (offset_o == 2'($past(offset_o) + 1'b1)));

    // R5
    xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && order_w == ORDER_XOR)
            |=> ((offset_o ^ $past(offset_o)) == (beat_w ^ $past(beat_w))));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (addr_o == '0));

endmodule

// File: tb/burst_addr_gen_tb.sv
// Bench: drives inputs on the falling edge and updates an integer model on
// the rising edge. It compares both outputs with the model at every falling
// edge.
module burst_addr_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          adv_n_i = 1'b1;
    logic          mode_i = 1'b0;
    logic [AW-1:0] addr_o;
    logic [1:0]    offset_o;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    bit    checking = 1'b0;
    bit    done     = 1'b0;

    int    m_hi = 0, m_start = 0, m_mode = 0, m_beat = 0, m_adv = 0;
    string m_tag = "R1";

    burst_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .addr_i   (addr_i),
        .adv_n_i  (adv_n_i),
        .mode_i   (mode_i),
        .addr_o   (addr_o),
        .offset_o (offset_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model, applied to the inputs sampled at each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_hi = 0; m_start = 0; m_mode = 0; m_beat = 0; m_adv = 0;
            m_tag = "R1";
        end else if (load_i) begin
            m_hi    = int'(addr_i) / 4;
            m_start = int'(addr_i) % 4;
            m_mode  = int'(mode_i);
            m_beat  = 0;
            m_adv   = 0;
            m_tag   = adv_n_i ? "R2" : "R3";
        end else if (!adv_n_i) begin
            m_adv++;
            m_beat = (m_beat + 1) % 4;
            if (int'(mode_i) != m_mode) m_tag = "R9";
            else if (m_adv > 3)         m_tag = "R8";
            else if (m_mode == 1)       m_tag = "R5";
            else                        m_tag = "R4";
        end else begin
            m_tag = "R6";
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Compare outputs with the model at every falling edge.
    always @(negedge clk) begin
        if (checking) begin
            int exp_off;
            exp_off = (m_mode == 1) ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
            check(m_tag, int'(offset_o), exp_off);
            check("R7", int'(addr_o) / 4, m_hi);
            check("R10", int'(offset_o), int'(addr_o) % 4);
        end
    end

    task automatic step(bit ld, logic [AW-1:0] a, bit adv_n, bit md);
        @(negedge clk);
        load_i  = ld;
        addr_i  = a;
        adv_n_i = adv_n;
        mode_i  = md;
    endtask

    task automatic advance(int n, bit md);
        for (int i = 0; i < n; i++) step(1'b0, 16'hFFFF, 1'b0, md);
    endtask

    // Watchdog: an overrun counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        step(1'b0, 16'h0000, 1'b1, 1'b0);
        step(1'b0, 16'h0000, 1'b0, 1'b1);
        step(1'b0, 16'h0000, 1'b1, 1'b0);
        @(negedge clk);
        // R1: reset values, seen before the release takes effect.
        check("R1", int'(addr_o), 0);
        rst_n = 1'b1;
        checking = 1'b1;

        // R2, R4, R8: linear burst from offset 2, run past four beats.
        step(1'b1, 16'hA5F2, 1'b1, 1'b0);
        advance(7, 1'b0);
        // R6: suspend the burst.
        step(1'b0, 16'h1234, 1'b1, 1'b1);
        step(1'b0, 16'h0000, 1'b1, 1'b0);
        advance(2, 1'b0);

        // R5: interleaved order from offset 1, then from offset 3.
        step(1'b1, 16'h3C01, 1'b1, 1'b1);
        advance(5, 1'b1);
        step(1'b1, 16'h7777, 1'b1, 1'b1);
        advance(3, 1'b1);
        step(1'b0, 16'h0000, 1'b1, 1'b1);
        advance(2, 1'b1);

        // R3: load together with an active advance.
        step(1'b1, 16'h0BEE, 1'b0, 1'b0);
        advance(2, 1'b0);
        step(1'b1, 16'hFFFE, 1'b0, 1'b1);
        advance(1, 1'b1);

        // R9: mode input flips during bursts in both orders.
        step(1'b1, 16'h4001, 1'b1, 1'b0);
        advance(4, 1'b1);
        step(1'b1, 16'h8002, 1'b1, 1'b1);
        advance(4, 1'b0);

        // R1 again: mid-burst reset.
        step(1'b0, 16'h0000, 1'b1, 1'b0);
        rst_n = 1'b0;
        step(1'b0, 16'h0000, 1'b1, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 16'h0000, 1'b1, 1'b0);
        @(negedge clk);

        checking = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule